// File: doc/BRIEF.md
# Criticality-Ordered Priority Selector

This block picks one of eight equal-width data words using a 3-bit binary index, just as a plain 8:1 multiplexer would. It is not built as a balanced tree. Instead, the data path is a linear chain of 2:1 stages. Each stage is enabled by a full decode of one index value, and a stage nearer the output overrides every stage behind it. The word whose arrival is the most timing-critical is placed at the stage that drives the output, so only one 2:1 level lies on its path. Less critical words sit further back in the chain.

The chain order is a parameter. It lists eight distinct indices, from the stage nearest the output to the far end of the chain, and a duplicate entry stops elaboration. The entry at the far end needs no decode. It is the fall-through value, and it is correct because the seven other decodes are mutually exclusive and, together with it, cover all eight index values. The default order puts word 5 nearest the output, followed by words 0, 1, 2, 3, 4, 6 and 7.

A small decoder turns the index into a struct of stage strobes, and a datapath module builds the chain from those strobes. The block is purely combinational.

Top module: `prio_sel_chain`

## Requirements
- R1: For every index value v in 0..7, `dataOut` equals word v, which is the `DATA_W`-bit field of `dataIn` starting at bit v*`DATA_W`.
- R2: Every bit of the output follows the same index, so the selected word is passed unchanged at any `DATA_W`, including bit patterns with mixed ones and zeros.
- R3: When the index equals the first entry of the chain order (word 5 by default), the output equals that word whatever the other seven words hold.
- R4: Words that are not selected have no effect on the output. Changing all seven of them leaves `dataOut` unchanged.
- R5: When the index equals the last entry of the chain order (word 7 by default), no stage strobe is active and the output is the fall-through word.
- R6: For any index, at most one stage strobe is active.
- R7: Any permutation of 0..7 used as the chain order gives exactly the same index-to-word function as the default order. An order that contains a duplicate index is rejected at elaboration.
- R8: The output follows a change of index or data with no clock edge, because the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| selIdx | input | 3 | Binary index of the word to pass |
| dataIn | input | 8*DATA_W | Eight packed data words, with word k at bits [k*DATA_W +: DATA_W] |
| dataOut | output | DATA_W | Selected word |

## Verification
Every index value is driven with several data patterns:
- Random words catch a wrong field offset.
- Complementary patterns, with the selected word all zeros among ones and the reverse, show whether any other word leaks through a stage.
- Alternating bit patterns show whether bits of the word get mixed up.

For the stage nearest the output and for the fall-through word, all other words are also scrambled while the index is held fixed. A second instance with the reversed chain order runs the same sweep, which shows that the order changes only the structure and never the result.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;
  localparam int unsigned NUM_WORDS = 8;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_HITS  = NUM_WORDS - 1;

  typedef struct packed {
    logic [NUM_HITS-1:0] hit;          // hit[k]: stage k owns the output
    logic                fallThrough;  // no stage decoded, chain end wins
  } stageStrobes_t;

  // true when the packed order is a permutation of 0..NUM_WORDS-1
  function automatic bit orderIsPerm(input logic [NUM_WORDS*SEL_W-1:0] ord);
    logic [NUM_WORDS-1:0] seen;
    seen = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      seen[ord[i*SEL_W +: SEL_W]] = 1'b1;
    end
    return &seen;
  endfunction
endpackage

// File: rtl/prio_sel_decode.sv
module prio_sel_decode
  import prio_sel_pkg::*;
#(
  parameter logic [NUM_WORDS*SEL_W-1:0] STAGE_ORDER = {3'd7, 3'd6, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd5}
) (
  input  logic [SEL_W-1:0] selIdx,
  output stageStrobes_t    strobes
);
  localparam logic [SEL_W-1:0] LAST_IDX = STAGE_ORDER[NUM_HITS*SEL_W +: SEL_W];

  logic [NUM_HITS-1:0] hitVec;

  for (genvar k = 0; k < NUM_HITS; k++) begin : gDec
    localparam logic [SEL_W-1:0] STAGE_IDX = STAGE_ORDER[k*SEL_W +: SEL_W];
    assign hitVec[k] = (selIdx == STAGE_IDX);
  end

  assign strobes.hit         = hitVec;
  assign strobes.fallThrough = ~|hitVec;

  always_comb begin
    AST_ONE_STAGE: assert ($onehot0(hitVec)) else $error("multiple stages decoded"); // R6
    if (~|hitVec) begin
      AST_FALL_IDX: assert (selIdx == LAST_IDX) else $error("fall-through on wrong index"); // R5
    end
  end
endmodule

// File: rtl/prio_sel_path.sv
module prio_sel_path
  import prio_sel_pkg::*;
#(
  parameter int unsigned                 DATA_W      = 1,
  parameter logic [NUM_WORDS*SEL_W-1:0] STAGE_ORDER = {3'd7, 3'd6, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd5}
) (
  input  logic [NUM_WORDS*DATA_W-1:0] dataIn,
  input  stageStrobes_t               strobes,
  output logic [DATA_W-1:0]           dataOut
);
  localparam int unsigned LAST_IDX  = STAGE_ORDER[NUM_HITS*SEL_W +: SEL_W];
  localparam int unsigned FIRST_IDX = STAGE_ORDER[0 +: SEL_W];

  // node[k] is the value leaving stage k; node[NUM_HITS] is the chain end
  logic [DATA_W-1:0] node [NUM_WORDS];

  assign node[NUM_HITS] = dataIn[LAST_IDX*DATA_W +: DATA_W];

  for (genvar k = NUM_HITS - 1; k >= 0; k--) begin : gStage
    localparam int unsigned WORD_IDX = STAGE_ORDER[k*SEL_W +: SEL_W];
    assign node[k] = strobes.hit[k] ? dataIn[WORD_IDX*DATA_W +: DATA_W] : node[k+1];
  end

  assign dataOut = node[0];

  always_comb begin
    if (strobes.hit[0]) begin
      AST_CRIT_PASS: assert (dataOut == dataIn[FIRST_IDX*DATA_W +: DATA_W]) else $error("critical word lost"); // R3
    end
    if (strobes.fallThrough) begin
      AST_FALL_WORD: assert (dataOut == dataIn[LAST_IDX*DATA_W +: DATA_W]) else $error("wrong fall-through word"); // R5
    end
  end
endmodule

// File: rtl/prio_sel_chain.sv
module prio_sel_chain
  import prio_sel_pkg::*;
#(
  parameter int unsigned                 DATA_W      = 1,
  parameter logic [NUM_WORDS*SEL_W-1:0] STAGE_ORDER = {3'd7, 3'd6, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd5}
) (
  input  logic [SEL_W-1:0]            selIdx,
  input  logic [NUM_WORDS*DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0]           dataOut
);
  localparam bit ORDER_OK = orderIsPerm(STAGE_ORDER);

  if (!ORDER_OK) begin : gBadOrder
    $error("STAGE_ORDER must list each index 0..7 once"); // R7
  end

  stageStrobes_t strobes;

  prio_sel_decode #(.STAGE_ORDER(STAGE_ORDER)) uDecode (
    .selIdx  (selIdx),
    .strobes (strobes)
  );

  prio_sel_path #(.DATA_W(DATA_W), .STAGE_ORDER(STAGE_ORDER)) uPath (
    .dataIn  (dataIn),
    .strobes (strobes),
    .dataOut (dataOut)
  );

  // plain indexed reference, separate from the chain
  logic [DATA_W-1:0] refWord;
  assign refWord = dataIn[selIdx*DATA_W +: DATA_W];

  always_comb begin
    AST_MATCH_PLAIN: assert (dataOut == refWord) else $error("chain differs from plain mux"); // R1
  end
endmodule

// File: tb/prio_sel_chain_test.sv
module prio_sel_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]      selIdx;
  logic [NW*W-1:0] dataIn;
  logic [W-1:0]    dataOut;
  logic [W-1:0]    altOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  prio_sel_chain #(.DATA_W(W)) uut (
    .selIdx(selIdx), .dataIn(dataIn), .dataOut(dataOut)
  );

  prio_sel_chain #(.DATA_W(W),
    .STAGE_ORDER({3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7})) uutAlt (
    .selIdx(selIdx), .dataIn(dataIn), .dataOut(altOut)
  );

  function automatic logic [W-1:0] expWord(input logic [NW*W-1:0] d, input int s);
    return W'((d >> (s*W)) & ((1 << W) - 1));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (sel=%0d data=%h)", req, act, exp, selIdx, dataIn);
    end
  endtask

  task automatic apply(input int s, input logic [NW*W-1:0] d);
    @(posedge clk);
    selIdx = 3'(s);
    dataIn = d;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] held;
    selIdx = '0;
    dataIn = '0;
    @(negedge clk);
    check("R1 reset-state zero", dataOut, '0);

    for (int s = 0; s < NW; s++) begin
      for (int r = 0; r < 6; r++) begin
        apply(s, {$urandom, $urandom} );
        check("R1 random", dataOut, expWord(dataIn, s));
        check("R7 alt order", altOut, expWord(dataIn, s));
      end
      // selected word zero among ones, then ones among zeros
      apply(s, ~({{(NW*W-W){1'b0}}, {W{1'b1}}} << (s*W)));
      check("R4 zero among ones", dataOut, '0);
      apply(s, {{(NW*W-W){1'b0}}, {W{1'b1}}} << (s*W));
      check("R4 ones among zeros", dataOut, {W{1'b1}});
      apply(s, {NW{4'b1010}});
      check("R2 pattern a", dataOut, 4'b1010);
      apply(s, 32'({4'b0101}) << (s*W));
      check("R2 pattern b", dataOut, 4'b0101);
    end

    // R3: critical word held, others scrambled
    apply(5, {$urandom, $urandom});
    held = dataOut;
    check("R3 crit word", held, expWord(dataIn, 5));
    for (int r = 0; r < 8; r++) begin
      apply(5, (dataIn & (32'hF << 20)) | ({$urandom, $urandom} & ~(32'hF << 20)));
      check("R3 crit stable", dataOut, held);
    end

    // R5: fall-through word with the rest scrambled
    for (int r = 0; r < 8; r++) begin
      apply(7, {4'h9, 28'($urandom)});
      check("R5 fall-through", dataOut, 4'h9);
    end

    // R8: output follows the index between edges
    @(posedge clk);
    dataIn = 32'h7654_3210;
    selIdx = 3'd2;
    #1;
    check("R8 immediate a", dataOut, 4'h2);
    selIdx = 3'd6;
    #1;
    check("R8 immediate b", dataOut, 4'h6);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule